// File: doc/BRIEF.md
# Daisy-Chained Panel Switch Reader

This block sits on a panel input board and reports the positions of eight panel switches to a bus master over a four-wire serial link. It runs from a local system clock and oversamples the link. A high switch input means the turnout is set diverging (thrown) and a low input means it is set straight through (closed). When the master pulls the active-low select line low, the block takes a snapshot of the synchronized switch levels into an eight-bit shift register. Each rising edge of the serial clock then moves the register one place toward the master, MSB first. At the same time the bit arriving from the upstream board enters at the LSB.

Boards are cascaded so that each board's serial output feeds the serial input of the board nearer the master. A master facing N boards therefore clocks 8×N bits in one select period. It reads the nearest board first. An end-of-chain strap turns the last board into a terminator that feeds zeros into the chain. The register clears to zero on reset, which lets the master find the chain length: it clocks a marker word in without a fresh select and counts bits until the marker comes back. The local LEDs mirror the switches at all times, whatever the bus is doing.

Top module: `sw_chain_slave`

## Requirements
- R1: After reset the shift register holds all zeros and `ser_out` is low.
- R2: A falling edge on `sel_n` loads the synchronized switch levels into the register. Bit 7 of `sw` is the first bit presented on `ser_out`, and a high bit means diverging.
- R3: While `sel_n` is low, each rising edge of `ser_clk` shifts the register toward bit 7 and takes `ser_in` into bit 0. `ser_out` shows the register's bit 7.
- R4: `ser_out` is held low while `sel_n` is high, and `ser_clk` edges then leave the register unchanged.
- R5: With two boards chained, one select period of 16 clocks returns the near board's eight switches followed by the far board's eight switches.
- R6: Switch positions cleared in parameter `USED_MASK` always load as 0.
- R7: With `chain_end` high, `ser_in` is ignored and zeros are shifted into bit 0.
- R8: `led` follows all eight `sw` inputs three system clocks after they change, whether or not a transfer is in progress and regardless of `USED_MASK`.
- R9: A marker shifted into a single board after reset, with no select edge, returns on `ser_out` after exactly eight zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select from the master |
| ser_clk | input | 1 | Serial shift clock from the master |
| ser_in | input | 1 | Serial data from the upstream board |
| chain_end | input | 1 | End-of-chain strap; when high, zeros enter bit 0 |
| sw | input | 8 | Panel switch levels, high = diverging |
| ser_out | output | 1 | Serial data toward the master |
| led | output | 8 | Local indicator drive, mirrors `sw` |

## Verification
The link inputs pass through two synchronizer flops and one edge-detect stage. A select fall or clock rise therefore changes the register on the third system clock, and `ser_out` changes on the fourth. An LED follows a switch change on the third clock. The bench holds every link level for eight system clocks. It samples `ser_out` just before the next serial clock rise, well past the four-clock latency. It checks `led` exactly two and three clocks after a switch change, so it sees both the old and the new value.

// File: rtl/sw_chain_pkg.sv
package sw_chain_pkg;
  typedef struct packed {
    logic load;   // select just asserted
    logic shift;  // serial clock rose while selected
    logic idle;   // select deasserted
  } bus_evt_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else     st[g] <= st[g-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/bus_edge.sv
module bus_edge
  import sw_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sel_n_s,
  input  logic     sclk_s,
  output bus_evt_t evt
);
  logic sel_n_q, sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n_q <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      sel_n_q <= sel_n_s;
      sclk_q  <= sclk_s;
    end
  end

  always_comb begin
    evt.load  = sel_n_q & ~sel_n_s;
    evt.shift = ~sclk_q & sclk_s & ~sel_n_s;
    evt.idle  = sel_n_s;
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import sw_chain_pkg::*;
#(
  parameter int         W         = 8,
  parameter logic [W-1:0] USED_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  bus_evt_t     evt,
  input  logic [W-1:0] par_in,
  input  logic         bit_in,
  output logic         sdo
);
  localparam int MSB = W - 1;
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)            sr <= '0;
    else if (evt.load)  sr <= par_in & USED_MASK;
    else if (evt.shift) sr <= {sr[MSB-1:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst || evt.idle) sdo <= 1'b0;
    else                 sdo <= sr[MSB];
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    evt.load |=> sr == ($past(par_in) & USED_MASK));
  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (evt.shift && !evt.load) |=> sr[MSB:1] == $past(sr[MSB-1:0]));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!evt.load && !evt.shift) |=> $stable(sr));
  assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    evt.idle |=> !sdo);
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
    evt.load |=> (sr & ~USED_MASK) == '0);
endmodule

// File: rtl/sw_chain_slave.sv
module sw_chain_slave
  import sw_chain_pkg::*;
#(
  parameter int           NSW       = 8,
  parameter int           SYNC      = 2,
  parameter logic [NSW-1:0] USED_MASK = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_n,
  input  logic           ser_clk,
  input  logic           ser_in,
  input  logic           chain_end,
  input  logic [NSW-1:0] sw,
  output logic           ser_out,
  output logic [NSW-1:0] led
);
  logic [2:0]     link_s;
  logic [NSW-1:0] sw_s;
  logic           core_bit;
  bus_evt_t       evt;

  sync_bank #(.WIDTH(3), .STAGES(SYNC)) u_link_sync (
    .clk(clk), .rst(rst), .din({sel_n, ser_clk, ser_in}), .dout(link_s));

  sync_bank #(.WIDTH(NSW), .STAGES(SYNC)) u_sw_sync (
    .clk(clk), .rst(rst), .din(sw), .dout(sw_s));

  bus_edge u_edge (
    .clk(clk), .rst(rst), .sel_n_s(link_s[2]), .sclk_s(link_s[1]), .evt(evt));

  assign core_bit = chain_end ? 1'b0 : link_s[0];

  shift_core #(.W(NSW), .USED_MASK(USED_MASK)) u_core (
    .clk(clk), .rst(rst), .evt(evt), .par_in(sw_s), .bit_in(core_bit),
    .sdo(ser_out));

  always_ff @(posedge clk) begin
    if (rst) led <= '0;
    else     led <= sw_s;
  end

  assert_one_event_R3: assert property (@(posedge clk) disable iff (rst)
    !(evt.idle && (evt.load || evt.shift)));
endmodule

// File: tb/sw_chain_slave_tb.sv
`timescale 1ns/1ps
module sw_chain_slave_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, sel_n = 1'b1, ser_clk = 1'b0, tb_sdi = 1'b0;
  logic use_chain = 1'b0, dut_end = 1'b0;
  logic [7:0] sw_dut = '0, sw_up = '0;
  logic up_out, dut_out, dut_sdi;
  logic [7:0] led_dut, led_up;
  int checks = 0, errors = 0;

  assign dut_sdi = use_chain ? up_out : tb_sdi;

  sw_chain_slave u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .ser_in(dut_sdi),
    .chain_end(dut_end), .sw(sw_dut), .ser_out(dut_out), .led(led_dut));

  sw_chain_slave #(.USED_MASK(8'h0F)) u_up (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .ser_in(1'b1),
    .chain_end(1'b1), .sw(sw_up), .ser_out(up_out), .led(led_up));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel_level);
    sel_n = sel_level; ser_clk = 1'b0; rst = 1'b1;
    cyc(4);
    rst = 1'b0;
    cyc(8);
  endtask

  task automatic xfer(input int n, input logic [31:0] din, input bit sel,
                      output logic [31:0] dout);
    dout = '0;
    if (sel) begin sel_n = 1'b0; cyc(8); end
    for (int i = 0; i < n; i++) begin
      dout = {dout[30:0], dut_out};
      tb_sdi = din[n-1-i];
      cyc(4);
      ser_clk = 1'b1; cyc(8);
      ser_clk = 1'b0; cyc(8);
    end
    if (sel) begin sel_n = 1'b1; cyc(8); end
  endtask

  task automatic t_reset;
    chk("R1 ser_out after reset", {31'b0, dut_out}, 32'h0);
    chk("R4 ser_out low while deselected", {31'b0, up_out}, 32'h0);
  endtask

  task automatic t_single_read;
    logic [31:0] d;
    sw_dut = 8'b1011_0010; cyc(4);
    xfer(8, 32'h0, 1'b1, d);
    chk("R2 snapshot read pattern A", d, 32'hB2);
    sw_dut = 8'h5A; cyc(4);
    xfer(8, 32'h0, 1'b1, d);
    chk("R2 snapshot read pattern B", d, 32'h5A);
  endtask

  task automatic t_shift_through;
    logic [31:0] d;
    sw_dut = 8'hE1; cyc(4);
    xfer(16, 32'h0000_C300, 1'b1, d);
    chk("R3 switches then upstream bits", d, 32'h0000_E1C3);
  endtask

  task automatic t_idle;
    logic [31:0] d;
    sw_dut = 8'hFF; cyc(4);
    for (int i = 0; i < 3; i++) begin
      ser_clk = 1'b1; cyc(8);
      chk("R4 ser_out low during deselected clocking", {31'b0, dut_out}, 32'h0);
      ser_clk = 1'b0; cyc(8);
    end
    sel_n = 1'b0; cyc(8);
    sel_n = 1'b1; cyc(8);
    chk("R4 ser_out low after deselect", {31'b0, dut_out}, 32'h0);
    xfer(8, 32'h0, 1'b1, d);
    chk("R4 register intact after idle clocks", d, 32'hFF);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    use_chain = 1'b1; sw_dut = 8'h96; sw_up = 8'h3C; cyc(4);
    xfer(16, 32'h0, 1'b1, d);
    chk("R5 two-board read", d, 32'h0000_960C);
    chk("R6 unused positions read zero", {24'b0, d[7:4]}, 32'h0);
    use_chain = 1'b0;
  endtask

  task automatic t_chain_end;
    logic [31:0] d;
    dut_end = 1'b1; sw_dut = 8'h7E; cyc(4);
    xfer(16, 32'h0000_FFFF, 1'b1, d);
    chk("R7 zeros enter at end of chain", d, 32'h0000_7E00);
    dut_end = 1'b0;
  endtask

  task automatic t_led;
    logic [31:0] d;
    sw_dut = 8'h11; sw_up = 8'hF0; cyc(6);
    sw_dut = 8'hA4; sw_up = 8'hC3;
    cyc(2);
    chk("R8 led unchanged at two clocks", {24'b0, led_dut}, 32'h11);
    cyc(1);
    chk("R8 led follows at three clocks", {24'b0, led_dut}, 32'hA4);
    chk("R8 led ignores mask", {24'b0, led_up}, 32'hC3);
    sel_n = 1'b0; cyc(8);
    sw_dut = 8'h3B; cyc(3);
    chk("R8 led follows during transfer", {24'b0, led_dut}, 32'h3B);
    sel_n = 1'b1; cyc(8);
    d = 0;
  endtask

  task automatic t_marker;
    logic [31:0] d;
    sw_dut = 8'hFF;
    do_reset(1'b0);
    xfer(16, 32'h0000_A500, 1'b0, d);
    chk("R9 zeros before marker", {24'b0, d[15:8]}, 32'h0);
    chk("R9 marker returns after eight bits", {24'b0, d[7:0]}, 32'hA5);
    sel_n = 1'b1;
    do_reset(1'b1);
    chk("R1 ser_out low after second reset", {31'b0, dut_out}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_reset();
    t_single_read();
    t_shift_through();
    t_idle();
    t_chain();
    t_chain_end();
    t_led();
    t_marker();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule